// File: doc/BRIEF.md
# Sleep-Aware ADC Conversion Sequencer

This block decides when an on-chip analog-to-digital converter begins a conversion. It also decides how the end of that conversion reaches a CPU that may be halted. A conversion can be launched in three ways: a software start request, an external trigger pulse when auto-triggering is on, or the CPU itself entering one of the two quiet sleep modes. The third way applies only when auto-triggering is off and the noise-canceller-disable control is clear. The converter is abstracted as a fixed cycle count that an internal timer tracks. A normal conversion takes 13 cycles. The first conversion after the enable control rises is an extended one of 25 cycles.

On completion the block sets a sticky interrupt flag. It raises an interrupt request whenever that flag is set and interrupts are enabled. If the CPU is still asleep, it also raises a wake request. A CPU woken early by some other source does not disturb the conversion in flight. Each entry into sleep can launch at most one conversion. Clearing the enable control aborts a running conversion without any completion event. All pins are plain control and status levels or single-cycle strobes. No data stream crosses the boundary, so no handshake applies.

Top module: `adc_sleep_seq`

## Requirements
- R1: After reset, busy, conv_start, conv_ext, conv_done, irq_flag, irq_req and wake_req are all 0.
- R2: With auto_trig_en=0 and nc_dis=0, adc_en=1 and busy=0, a rising edge of cpu_asleep while sleep_mode is 0 (idle) or 1 (noise reduction) launches a conversion. conv_start pulses for one cycle, one clock after the edge is sampled.
- R3: A rising edge of cpu_asleep with sleep_mode of 2 or higher launches nothing and leaves adc_en in force. A later software start then runs a normal-length conversion.
- R4: With nc_dis=1 and auto_trig_en=1, entering sleep modes 0 or 1 launches nothing. A trig_pulse while auto_trig_en=1, adc_en=1 and busy=0 launches a conversion.
- R5: sw_start launches a conversion when adc_en=1 and busy=0. Any start request while busy=1 is ignored: it neither restarts nor lengthens the conversion, and it adds no conv_start pulse.
- R6: busy stays high for exactly 13 cycles in a normal conversion. It stays high for 25 cycles in the first conversion after adc_en goes from 0 to 1, and conv_ext is 1 for that extended conversion only.
- R7: On completion, conv_done pulses for one cycle and irq_flag sets. irq_flag holds until irq_ack or flag_clr is high. irq_req equals irq_flag gated by irq_en.
- R8: wake_req is high while irq_req is high and cpu_asleep is 1. If the CPU wakes before completion, the conversion still runs to its full length and still sets irq_flag.
- R9: One sleep entry launches at most one conversion. Remaining asleep after a conversion completes launches no further conversion until cpu_asleep falls and rises again.
- R10: Driving adc_en low during a conversion clears busy at the next clock edge. No conv_done pulse follows and irq_flag is not set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_asleep | input | 1 | CPU halted in a low-power state |
| sleep_mode | input | 3 | Selected sleep mode: 0 idle, 1 noise reduction, others deeper |
| adc_en | input | 1 | Converter enable |
| auto_trig_en | input | 1 | Auto-trigger enable (0 selects single conversion mode) |
| nc_dis | input | 1 | Noise-canceller disable: blocks sleep-entry starts |
| sw_start | input | 1 | Software start request |
| trig_pulse | input | 1 | External trigger event |
| irq_en | input | 1 | Completion interrupt enable |
| irq_ack | input | 1 | Interrupt acknowledge, clears the flag |
| flag_clr | input | 1 | Software clear of the flag |
| conv_start | output | 1 | One-cycle start strobe to the converter |
| conv_ext | output | 1 | Current or last conversion is the extended kind |
| conv_done | output | 1 | One-cycle completion strobe |
| busy | output | 1 | Conversion in progress |
| irq_flag | output | 1 | Sticky completion flag |
| irq_req | output | 1 | Completion interrupt request |
| wake_req | output | 1 | Request to wake the CPU |

## Verification
Suppose the cycle counter is corrupted or loaded with the wrong length. The busy window then comes out other than 13 or 25 cycles, visible at the first completion. The same applies to a lost extended-pending state, which shows as a first conversion of 13 cycles. A stale sleep-edge register shows either as a missing conv_start one cycle after sleep entry or as a second conversion while the CPU stays asleep, caught within a few dozen cycles. Faults in the flag logic show in the cycle after conv_done as a wrong irq_req or wake_req, or as a flag that sets after an abort.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  // Sleep mode codes in which a halted CPU may launch a conversion
  localparam int unsigned SLP_IDLE = 0;
  localparam int unsigned SLP_NRED = 1;

  // True when the mode code is one of the two quiet modes
  function automatic logic is_quiet_mode(input int unsigned code);
    return (code == SLP_IDLE) || (code == SLP_NRED);
  endfunction

endpackage

// File: rtl/seq_start_arb.sv
module seq_start_arb #(
  parameter int MODE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_asleep,
  input  logic [MODE_W-1:0] sleep_mode,
  input  logic              adc_en,
  input  logic              auto_trig_en,
  input  logic              nc_dis,
  input  logic              sw_start,
  input  logic              trig_pulse,
  input  logic              busy,
  output logic              start_go
);
  import adc_seq_pkg::*;

  logic asleep_q;
  logic sleep_rise;
  logic quiet;
  logic sleep_ok;
  logic trig_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) asleep_q <= 1'b0;
    else        asleep_q <= cpu_asleep;
  end

  // A sleep entry is the only moment a halted CPU can launch a conversion
  assign sleep_rise = cpu_asleep & ~asleep_q;
  assign quiet      = is_quiet_mode(int'(sleep_mode));
  assign sleep_ok   = sleep_rise & quiet & ~auto_trig_en & ~nc_dis;
  assign trig_ok    = trig_pulse & auto_trig_en;

  assign start_go = adc_en & ~busy & (sw_start | trig_ok | sleep_ok);

  // R9: one sleep launch per entry: a held sleep level without trigger or software cannot launch
  a_r9_one_per_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (asleep_q && cpu_asleep && !sw_start && !trig_pulse) |-> !start_go);

endmodule

// File: rtl/seq_conv_timer.sv
module seq_conv_timer #(
  parameter int NORM_CYC = 13,
  parameter int EXT_CYC  = 25
) (
  input  logic clk,
  input  logic rst_n,
  input  logic adc_en,
  input  logic start_go,
  output logic busy,
  output logic conv_start,
  output logic conv_ext,
  output logic conv_done
);
  localparam int CNT_W = $clog2(EXT_CYC);
  localparam logic [CNT_W-1:0] NORM_LD = CNT_W'(NORM_CYC - 1);
  localparam logic [CNT_W-1:0] EXT_LD  = CNT_W'(EXT_CYC - 1);

  logic             en_q;
  logic             ext_pend;
  logic             en_rise;
  logic             ext_now;
  logic [CNT_W-1:0] cnt;

  assign en_rise = adc_en & ~en_q;
  assign ext_now = ext_pend | en_rise;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q       <= 1'b0;
      ext_pend   <= 1'b0;
      busy       <= 1'b0;
      conv_start <= 1'b0;
      conv_ext   <= 1'b0;
      conv_done  <= 1'b0;
      cnt        <= '0;
    end else begin
      en_q       <= adc_en;
      conv_start <= 1'b0;
      conv_done  <= 1'b0;
      if (en_rise) ext_pend <= 1'b1;
      if (!adc_en) begin
        // abort: no completion event
        busy <= 1'b0;
        cnt  <= '0;
      end else if (busy) begin
        if (cnt == '0) begin
          busy      <= 1'b0;
          conv_done <= 1'b1;
        end else begin
          cnt <= cnt - 1'b1;
        end
      end else if (start_go) begin
        busy       <= 1'b1;
        conv_start <= 1'b1;
        conv_ext   <= ext_now;
        cnt        <= ext_now ? EXT_LD : NORM_LD;
        ext_pend   <= 1'b0;
      end
    end
  end

  // Checker-only run length counter
  logic [CNT_W:0] chk_len;
  always_ff @(posedge clk) begin
    if (!rst_n || !busy) chk_len <= '0;
    else                 chk_len <= chk_len + 1'b1;
  end

  // R6: a completed conversion lasted the length selected by its kind
  a_r6_run_length: assert property (@(posedge clk) disable iff (!rst_n)
    conv_done |-> (chk_len == (conv_ext ? (CNT_W+1)'(EXT_CYC) : (CNT_W+1)'(NORM_CYC))));

  // R10: disabling mid-conversion aborts with no completion
  a_r10_abort: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !adc_en) |=> (!busy && !conv_done));

  // R7: completion strobe only ends a running conversion
  a_r7_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
    conv_done |-> $past(busy));

endmodule

// File: rtl/seq_irq_ctrl.sv
module seq_irq_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic conv_done,
  input  logic irq_en,
  input  logic irq_ack,
  input  logic flag_clr,
  input  logic cpu_asleep,
  output logic irq_flag,
  output logic irq_req,
  output logic wake_req
);

  always_ff @(posedge clk) begin
    if (!rst_n)                   irq_flag <= 1'b0;
    else if (conv_done)           irq_flag <= 1'b1;
    else if (irq_ack || flag_clr) irq_flag <= 1'b0;
  end

  assign irq_req  = irq_flag & irq_en;
  assign wake_req = irq_req & cpu_asleep;

  // R7: flag is sticky until cleared
  a_r7_flag_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_flag && !irq_ack && !flag_clr) |=> irq_flag);

  // R7: completion with interrupts enabled yields a request
  a_r7_done_req: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_done && irq_en) |=> (irq_flag && (irq_req || !irq_en)));

  // R8: wake only accompanies an interrupt request
  a_r8_wake_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
    wake_req |-> irq_flag);

endmodule

// File: rtl/adc_sleep_seq.sv
module adc_sleep_seq #(
  parameter int MODE_W   = 3,
  parameter int NORM_CYC = 13,
  parameter int EXT_CYC  = 25
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_asleep,
  input  logic [MODE_W-1:0] sleep_mode,
  input  logic              adc_en,
  input  logic              auto_trig_en,
  input  logic              nc_dis,
  input  logic              sw_start,
  input  logic              trig_pulse,
  input  logic              irq_en,
  input  logic              irq_ack,
  input  logic              flag_clr,
  output logic              conv_start,
  output logic              conv_ext,
  output logic              conv_done,
  output logic              busy,
  output logic              irq_flag,
  output logic              irq_req,
  output logic              wake_req
);

  logic start_go;

  seq_start_arb #(.MODE_W(MODE_W)) u_arb (
    .clk          (clk),
    .rst_n        (rst_n),
    .cpu_asleep   (cpu_asleep),
    .sleep_mode   (sleep_mode),
    .adc_en       (adc_en),
    .auto_trig_en (auto_trig_en),
    .nc_dis       (nc_dis),
    .sw_start     (sw_start),
    .trig_pulse   (trig_pulse),
    .busy         (busy),
    .start_go     (start_go)
  );

  seq_conv_timer #(.NORM_CYC(NORM_CYC), .EXT_CYC(EXT_CYC)) u_tmr (
    .clk        (clk),
    .rst_n      (rst_n),
    .adc_en     (adc_en),
    .start_go   (start_go),
    .busy       (busy),
    .conv_start (conv_start),
    .conv_ext   (conv_ext),
    .conv_done  (conv_done)
  );

  seq_irq_ctrl u_irq (
    .clk        (clk),
    .rst_n      (rst_n),
    .conv_done  (conv_done),
    .irq_en     (irq_en),
    .irq_ack    (irq_ack),
    .flag_clr   (flag_clr),
    .cpu_asleep (cpu_asleep),
    .irq_flag   (irq_flag),
    .irq_req    (irq_req),
    .wake_req   (wake_req)
  );

  // R5: the arbiter never launches into a running conversion
  a_r5_no_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !start_go);

  // R2: a launch decision produces a start strobe and busy next cycle
  a_r2_start_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    start_go |=> (busy && conv_start));

endmodule

// File: tb/tb_adc_sleep_seq.sv
module tb_adc_sleep_seq;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cpu_asleep = 1'b0;
  logic [2:0] sleep_mode = 3'd0;
  logic       adc_en = 1'b0, auto_trig_en = 1'b0, nc_dis = 1'b0;
  logic       sw_start = 1'b0, trig_pulse = 1'b0;
  logic       irq_en = 1'b0, irq_ack = 1'b0, flag_clr = 1'b0;
  logic       conv_start, conv_ext, conv_done, busy, irq_flag, irq_req, wake_req;

  int checks = 0;
  int fails  = 0;
  int start_cnt = 0;
  int exp_q[$];
  bit done_flag = 1'b0;

  always #10 clk = ~clk;

  adc_sleep_seq dut (
    .clk(clk), .rst_n(rst_n), .cpu_asleep(cpu_asleep), .sleep_mode(sleep_mode),
    .adc_en(adc_en), .auto_trig_en(auto_trig_en), .nc_dis(nc_dis),
    .sw_start(sw_start), .trig_pulse(trig_pulse), .irq_en(irq_en),
    .irq_ack(irq_ack), .flag_clr(flag_clr), .conv_start(conv_start),
    .conv_ext(conv_ext), .conv_done(conv_done), .busy(busy),
    .irq_flag(irq_flag), .irq_req(irq_req), .wake_req(wake_req)
  );

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic step(input int n);
    repeat (n) begin @(posedge clk); #2; end
  endtask

  // Driver side: expected busy length (0 means aborted)
  task automatic exp_conv(input int len);
    exp_q.push_back(len);
  endtask

  task automatic pulse_sw();
    sw_start = 1'b1; step(1); sw_start = 1'b0;
  endtask

  task automatic clear_flag();
    flag_clr = 1'b1; step(1); flag_clr = 1'b0;
  endtask

  // Monitor: measures each conversion and compares with the scoreboard
  int  run_len = 0;
  bit  prev_busy = 1'b0;
  bit  cur_ext = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (conv_start) begin
        start_cnt++;
        cur_ext = conv_ext;
      end
      if (busy) run_len++;
      else if (prev_busy) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R5 unexpected conversion", run_len, 0);
        end else begin
          int e;
          e = exp_q.pop_front();
          if (e == 0) begin
            check(!conv_done && run_len < 13, "R10 abort", run_len, 0);
          end else begin
            check(run_len == e, "R6 busy length", run_len, e);
            check(conv_done, "R7 done strobe", int'(conv_done), 1);
            check(cur_ext == (e == 25), "R6 ext kind", int'(cur_ext), int'(e == 25));
          end
        end
        run_len = 0;
      end
      prev_busy = busy;
    end
  end

  initial begin
    fork
      begin
        step(3);
        rst_n = 1'b1;
        step(1);
        // R1 reset state
        check({busy, conv_start, conv_ext, conv_done, irq_flag, irq_req, wake_req} == 7'b0,
              "R1 reset outputs", int'({busy, conv_start, conv_ext, conv_done, irq_flag, irq_req, wake_req}), 0);

        // R6 extended first conversion, software started (R5)
        adc_en = 1'b1; irq_en = 1'b1;
        step(2);
        exp_conv(25);
        pulse_sw();
        step(30);
        check(irq_req, "R7 irq_req after done", int'(irq_req), 1);
        check(!wake_req, "R8 no wake while awake", int'(wake_req), 0);
        step(3);
        check(irq_flag, "R7 flag sticky", int'(irq_flag), 1);
        irq_ack = 1'b1; step(1); irq_ack = 1'b0;
        check(!irq_flag, "R7 ack clears", int'(irq_flag), 0);

        // R5 start ignored while busy, R7 irq_en gating
        irq_en = 1'b0;
        begin
          int s0;
          s0 = start_cnt;
          exp_conv(13);
          pulse_sw();
          step(4);
          pulse_sw();
          step(20);
          check(start_cnt - s0 == 1, "R5 ignored start", start_cnt - s0, 1);
        end
        check(irq_flag && !irq_req, "R7 irq_en gates request", int'(irq_req), 0);
        irq_en = 1'b1;
        clear_flag();

        // R2 sleep entry in idle mode, R8 wake, R9 one per entry
        sleep_mode = 3'd0;
        exp_conv(13);
        begin
          int s0;
          s0 = start_cnt;
          cpu_asleep = 1'b1;
          step(1);
          check(conv_start, "R2 start strobe timing", int'(conv_start), 1);
          step(16);
          check(wake_req, "R8 wake on completion", int'(wake_req), 1);
          clear_flag();
          step(30);
          check(start_cnt - s0 == 1, "R9 single launch per sleep", start_cnt - s0, 1);
        end
        cpu_asleep = 1'b0;
        step(2);

        // R2 noise-reduction mode, R8 early wake by another source
        sleep_mode = 3'd1;
        exp_conv(13);
        cpu_asleep = 1'b1;
        step(5);
        cpu_asleep = 1'b0;
        step(15);
        check(irq_req && !wake_req, "R8 early wake still completes", int'(irq_req), 1);
        clear_flag();

        // R3 deeper mode: no launch, enable kept, normal length afterwards
        sleep_mode = 3'd3;
        begin
          int s0;
          s0 = start_cnt;
          cpu_asleep = 1'b1;
          step(10);
          check(start_cnt == s0 && !busy, "R3 deep sleep no launch", start_cnt - s0, 0);
        end
        exp_conv(13);
        pulse_sw();
        step(16);
        check(wake_req, "R3 wake from deep sleep on completion", int'(wake_req), 1);
        clear_flag();
        cpu_asleep = 1'b0;
        step(2);

        // R4 noise canceller disabled with auto trigger
        nc_dis = 1'b1; auto_trig_en = 1'b1; sleep_mode = 3'd0;
        begin
          int s0;
          s0 = start_cnt;
          cpu_asleep = 1'b1;
          step(10);
          check(start_cnt == s0, "R4 sleep entry no launch", start_cnt - s0, 0);
        end
        exp_conv(13);
        trig_pulse = 1'b1; step(1); trig_pulse = 1'b0;
        step(16);
        check(irq_flag, "R4 trigger conversion completed", int'(irq_flag), 1);
        cpu_asleep = 1'b0; nc_dis = 1'b0; auto_trig_en = 1'b0;
        clear_flag();

        // R10 abort
        exp_conv(0);
        pulse_sw();
        step(5);
        adc_en = 1'b0;
        step(3);
        check(!busy && !irq_flag, "R10 abort no flag", int'(irq_flag), 0);

        // R6 re-enable gives extended again
        adc_en = 1'b1;
        step(1);
        exp_conv(25);
        pulse_sw();
        step(30);
        check(exp_q.size() == 0, "R6 scoreboard drained", exp_q.size(), 0);
        done_flag = 1'b1;
      end
      begin
        repeat (100000) @(posedge clk);
        if (!done_flag) check(1'b0, "watchdog", 0, 1);
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule